// File: doc/BRIEF.md
# UART FIFO Control with Programmable Trigger Levels

This block sits between the host register interface of a serial port and its transmit and receive shift registers. It keeps one transmit queue and one receive queue of 16 bytes each. It decodes a write-only control byte that turns queue mode on or off, empties either queue on request, and selects a trigger level for each direction. When queue mode is off, each queue collapses to a single-byte holding register.

The host side pushes bytes into the transmit queue and pops bytes from the receive queue. The shift-register side pops from the transmit queue and pushes into the receive queue. The block reports count, full and empty for each queue, and a one-cycle overrun pulse when a push meets a full queue. It also raises two trigger flags. The receive flag means that enough bytes are waiting to be fetched. The transmit flag means that few enough bytes are left to send. Interrupt encoding, framing, baud timing and the shift registers themselves are handled elsewhere.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After synchronous reset, both counts are 0, both queues are empty and not full, queue mode is off, both read-data outputs are 0, no overrun pulse is set, rx_trig is 0 and tx_trig is 1.
- R2: A control write sets fifo_mode from control bit 0 one cycle later. Each queue holds 16 bytes when fifo_mode is 1 and 1 byte when it is 0.
- R3: Each queue returns bytes in push order. Count, full (count equals capacity) and empty (count 0) are registered and update one cycle after a push or pop. A push and a pop in the same cycle on a full queue are both accepted.
- R4: A push to a full queue without a pop in the same cycle is dropped and leaves the contents unchanged. The queue's overrun output is high for exactly the next cycle.
- R5: A pop takes effect only when the queue is not empty, and read data appears one cycle after it. A pop on an empty queue leaves the read data and the count unchanged.
- R6: A control write with bit 0 = 1 and bit 1 = 1 empties the receive queue at that clock edge and leaves the transmit queue unchanged. With bit 0 = 0, bit 1 has no effect.
- R7: A control write with bit 0 = 1 and bit 2 = 1 empties the transmit queue at that clock edge and leaves the receive queue unchanged. With bit 0 = 0, bit 2 has no effect.
- R8: Control bits 1 and 2 are not held. After a write that empties a queue, later pushes fill it normally.
- R9: Control bits 5:4 select the transmit level on every control write (00 = 1, 01 = 4, 10 = 8, 11 = 12). In queue mode, tx_trig is high while tx_count is at or below that level.
- R10: Control bits 7:6 select the receive level on every control write (00 = 1, 01 = 4, 10 = 8, 11 = 12). In queue mode, rx_trig is high while rx_count is at or above that level.
- R11: With queue mode off, rx_trig follows "receive holding byte present" (rx_count = 1) and tx_trig follows "transmit holding byte absent" (tx_count = 0).
- R12: A control write whose bit 0 differs from the current fifo_mode empties both queues at that clock edge.
- R13: Control bit 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| tx_push | input | 1 | Host writes a byte to the transmit queue |
| tx_wdata | input | 8 | Byte written to the transmit queue |
| tx_pop | input | 1 | Transmit shift side takes a byte |
| tx_rdata | output | 8 | Byte taken by the last accepted transmit pop |
| tx_count | output | 5 | Bytes in the transmit queue |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| tx_ovr | output | 1 | Pulse: transmit push dropped |
| tx_trig | output | 1 | Transmit level flag |
| rx_push | input | 1 | Receive shift side delivers a byte |
| rx_wdata | input | 8 | Byte delivered to the receive queue |
| rx_pop | input | 1 | Host reads a byte from the receive queue |
| rx_rdata | output | 8 | Byte taken by the last accepted receive pop |
| rx_count | output | 5 | Bytes in the receive queue |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovr | output | 1 | Pulse: receive push dropped |
| rx_trig | output | 1 | Receive level flag |
| fifo_mode | output | 1 | Queue mode active |

## Verification
The properties assume that the strobes are single-cycle, level-sampled inputs that are never X after reset. The full-push and empty-pop properties also assume that no control write lands in the same cycle, since a write may empty a queue and override the push or pop. The stimulus drives every strobe at the falling edge and holds it for one cycle. It keeps control writes in cycles of their own, apart from pushes and pops. It never pops a queue in the cycle in which a control write empties it.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_12 = 2'b11
  } trig_sel_e;

  // Byte threshold for a level code: 1, then steps of four.
  function automatic int unsigned trig_bytes(trig_sel_e sel);
    return (sel == TRIG_1) ? 1 : 4 * int'(sel);
  endfunction

endpackage

// File: rtl/fifo_cfg_reg.sv
module fifo_cfg_reg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       mode,
  output trig_sel_e  tx_sel,
  output trig_sel_e  rx_sel,
  output logic       rx_clr,
  output logic       tx_clr
);

  logic mode_chg;
  logic unused_bit3;

  assign unused_bit3 = wdata[3];

  // Clear strobes are decoded straight from the write, so no clear bit is ever stored.
  always_comb begin
    mode_chg = wr && (wdata[0] != mode);
    rx_clr   = mode_chg || (wr && wdata[0] && wdata[1]);
    tx_clr   = mode_chg || (wr && wdata[0] && wdata[2]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= 1'b0;
      tx_sel <= TRIG_1;
      rx_sel <= TRIG_1;
    end else if (wr) begin
      mode   <= wdata[0];
      tx_sel <= trig_sel_e'(wdata[5:4]);
      rx_sel <= trig_sel_e'(wdata[7:6]);
    end
  end

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       deep,
  input  logic                       push,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       pop,
  output logic [DATA_W-1:0]          rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       ovr
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cap, cnt_nxt;
  logic              pop_ok, push_ok;

  assign cap     = deep ? CW'(DEPTH) : CW'(1);
  assign pop_ok  = pop && !empty && !clr;
  assign push_ok = push && (!full || pop_ok) && !clr;

  always_comb begin
    if (clr)
      cnt_nxt = '0;
    else
      cnt_nxt = count + CW'(push_ok) - CW'(pop_ok);
  end

  // Storage array: no reset, one write port, registered read, so block RAM fits.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (pop_ok)
      rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
      ovr   <= 1'b0;
    end else begin
      count <= cnt_nxt;
      full  <= (cnt_nxt == cap);
      empty <= (cnt_nxt == '0);
      ovr   <= push && !push_ok && !clr;
    end
  end

endmodule

// File: rtl/trig_flag.sv
module trig_flag
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter bit IS_TX = 1'b0
) (
  input  logic                       deep,
  input  trig_sel_e                  sel,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       flag
);

  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] lvl;
  assign lvl = CW'(trig_bytes(sel));

  generate
    if (IS_TX) begin : g_tx
      // Few enough bytes left to send; holding mode: register empty.
      assign flag = deep ? (count <= lvl) : (count == '0);
    end else begin : g_rx
      // Enough bytes waiting; holding mode: register occupied.
      assign flag = deep ? (count >= lvl) : (count != '0);
    end
  endgenerate

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       tx_push,
  input  logic [DATA_W-1:0]          tx_wdata,
  input  logic                       tx_pop,
  output logic [DATA_W-1:0]          tx_rdata,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       tx_full,
  output logic                       tx_empty,
  output logic                       tx_ovr,
  output logic                       tx_trig,
  input  logic                       rx_push,
  input  logic [DATA_W-1:0]          rx_wdata,
  input  logic                       rx_pop,
  output logic [DATA_W-1:0]          rx_rdata,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       rx_full,
  output logic                       rx_empty,
  output logic                       rx_ovr,
  output logic                       rx_trig,
  output logic                       fifo_mode
);

  trig_sel_e tx_sel, rx_sel;
  logic      tx_clr, rx_clr;

  fifo_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .mode   (fifo_mode),
    .tx_sel (tx_sel),
    .rx_sel (rx_sel),
    .rx_clr (rx_clr),
    .tx_clr (tx_clr)
  );

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
    .clk   (clk),
    .rst   (rst),
    .clr   (tx_clr),
    .deep  (fifo_mode),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop),
    .rdata (tx_rdata),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty),
    .ovr   (tx_ovr)
  );

  byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
    .clk   (clk),
    .rst   (rst),
    .clr   (rx_clr),
    .deep  (fifo_mode),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty),
    .ovr   (rx_ovr)
  );

  trig_flag #(.DEPTH(DEPTH), .IS_TX(1'b1)) u_tx_trig (
    .deep  (fifo_mode),
    .sel   (tx_sel),
    .count (tx_count),
    .flag  (tx_trig)
  );

  trig_flag #(.DEPTH(DEPTH), .IS_TX(1'b0)) u_rx_trig (
    .deep  (fifo_mode),
    .sel   (rx_sel),
    .count (rx_count),
    .flag  (rx_trig)
  );

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfg_wr,
  input logic [7:0]                 cfg_wdata,
  input logic                       fifo_mode,
  input logic                       tx_push,
  input logic                       tx_pop,
  input logic [DATA_W-1:0]          tx_rdata,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic                       tx_full,
  input logic                       tx_empty,
  input logic                       tx_trig,
  input logic                       rx_push,
  input logic                       rx_pop,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       rx_full,
  input logic                       rx_empty,
  input logic                       rx_ovr,
  input logic                       rx_trig
);

  assert_mode_follow_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (fifo_mode == $past(cfg_wdata[0])));

  assert_hold_cap_R2: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |-> (rx_count <= 1 && tx_count <= 1));

  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_full, rx_empty}) && $onehot0({tx_full, tx_empty}));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_full && rx_push && !rx_pop && !cfg_wr) |=> (rx_ovr && rx_full));

  assert_ovr_cause_R4: assert property (@(posedge clk) disable iff (rst)
    rx_ovr |-> $past(rx_push && rx_full));

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && tx_pop && !tx_push && !cfg_wr) |=> ($stable(tx_rdata) && tx_empty));

  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata[0] && cfg_wdata[1]) |=> (rx_count == 0));

  assert_tx_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata[0] && cfg_wdata[2]) |=> (tx_count == 0));

  assert_tx_trig_full_R9: assert property (@(posedge clk) disable iff (rst)
    tx_full |-> !tx_trig);

  assert_rx_trig_empty_R10: assert property (@(posedge clk) disable iff (rst)
    rx_empty |-> !rx_trig);

  assert_mode_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_wdata[0] != fifo_mode)) |=> (rx_count == 0 && tx_count == 0));

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .fifo_mode (fifo_mode),
  .tx_push   (tx_push),
  .tx_pop    (tx_pop),
  .tx_rdata  (tx_rdata),
  .tx_count  (tx_count),
  .tx_full   (tx_full),
  .tx_empty  (tx_empty),
  .tx_trig   (tx_trig),
  .rx_push   (rx_push),
  .rx_pop    (rx_pop),
  .rx_count  (rx_count),
  .rx_full   (rx_full),
  .rx_empty  (rx_empty),
  .rx_ovr    (rx_ovr),
  .rx_trig   (rx_trig)
);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic [7:0] tx_rdata, rx_rdata;
  logic [4:0] tx_count, rx_count;
  logic       tx_full, tx_empty, tx_ovr, tx_trig;
  logic       rx_full, rx_empty, rx_ovr, rx_trig;
  logic       fifo_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  byte unsigned q_tx[$], q_rx[$];
  byte unsigned exp_tx[$], exp_rx[$];
  bit m_mode = 1'b0;
  int m_txl = 1, m_rxl = 1;

  always #2 clk = ~clk;

  uart_fifo_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_count(tx_count), .tx_full(tx_full), .tx_empty(tx_empty), .tx_ovr(tx_ovr),
    .tx_trig(tx_trig),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_full(rx_full), .rx_empty(rx_empty), .rx_ovr(rx_ovr),
    .rx_trig(rx_trig), .fifo_mode(fifo_mode)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl_of(logic [1:0] s);
    return (s == 2'b00) ? 1 : 4 * int'(s);
  endfunction

  task automatic check_state(string req);
    int cap = m_mode ? 16 : 1;
    check({req, " tx_count"}, int'(tx_count), q_tx.size());
    check({req, " rx_count"}, int'(rx_count), q_rx.size());
    check({req, " R3 tx_full"}, int'(tx_full), int'(q_tx.size() == cap));
    check({req, " R3 rx_full"}, int'(rx_full), int'(q_rx.size() == cap));
    check({req, " R3 tx_empty"}, int'(tx_empty), int'(q_tx.size() == 0));
    check({req, " R3 rx_empty"}, int'(rx_empty), int'(q_rx.size() == 0));
    check({req, " R2 mode"}, int'(fifo_mode), int'(m_mode));
    if (m_mode) begin
      check({req, " R9 tx_trig"}, int'(tx_trig), int'(q_tx.size() <= m_txl));
      check({req, " R10 rx_trig"}, int'(rx_trig), int'(q_rx.size() >= m_rxl));
    end else begin
      check({req, " R11 tx_trig"}, int'(tx_trig), int'(q_tx.size() == 0));
      check({req, " R11 rx_trig"}, int'(rx_trig), int'(q_rx.size() == 1));
    end
  endtask

  // Driver: one cycle of queue traffic, with the model updated alongside.
  task automatic drive(bit rpu, byte unsigned rd, bit rpo,
                       bit tpu, byte unsigned td, bit tpo, string req);
    int cap = m_mode ? 16 : 1;
    bit r_pok, r_uok, t_pok, t_uok;
    byte unsigned r_out = 0, t_out = 0;
    r_pok = rpo && q_rx.size() > 0;
    r_uok = rpu && (q_rx.size() < cap || r_pok);
    t_pok = tpo && q_tx.size() > 0;
    t_uok = tpu && (q_tx.size() < cap || t_pok);
    rx_push = rpu; rx_wdata = rd; rx_pop = rpo;
    tx_push = tpu; tx_wdata = td; tx_pop = tpo;
    if (r_pok) r_out = q_rx.pop_front();
    if (t_pok) t_out = q_tx.pop_front();
    if (r_uok) q_rx.push_back(rd);
    if (t_uok) q_tx.push_back(td);
    @(negedge clk);
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    if (r_pok) exp_rx.push_back(r_out);
    if (t_pok) exp_tx.push_back(t_out);
    check({req, " R4 rx_ovr"}, int'(rx_ovr), int'(rpu && !r_uok));
    check({req, " R4 tx_ovr"}, int'(tx_ovr), int'(tpu && !t_uok));
    check_state(req);
  endtask

  task automatic cfg(logic [7:0] w, string req);
    cfg_wr = 1'b1; cfg_wdata = w;
    if (w[0] != m_mode) begin
      q_rx.delete(); q_tx.delete();
    end else if (w[0]) begin
      if (w[1]) q_rx.delete();
      if (w[2]) q_tx.delete();
    end
    m_mode = w[0];
    m_txl = lvl_of(w[5:4]);
    m_rxl = lvl_of(w[7:6]);
    @(negedge clk);
    cfg_wr = 1'b0;
    check_state(req);
  endtask

  // Monitor: compares read data against the scoreboard a cycle after each pop.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_rx.size() > 0) check("R3 R5 rx_rdata order", int'(rx_rdata), int'(exp_rx.pop_front()));
      if (exp_tx.size() > 0) check("R3 R5 tx_rdata order", int'(tx_rdata), int'(exp_tx.pop_front()));
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    check("R1 rx_rdata", int'(rx_rdata), 0);
    check("R1 tx_rdata", int'(tx_rdata), 0);
    check("R1 ovr", int'(rx_ovr | tx_ovr), 0);

    // Holding mode: one byte each way (R11, R4, R5)
    drive(1, 8'hA5, 0, 1, 8'h3C, 0, "R11 hold push");
    drive(1, 8'h5A, 0, 1, 8'h77, 0, "R4 hold overrun");
    drive(0, 0, 1, 0, 0, 0, "R3 hold pop");
    drive(0, 0, 1, 0, 0, 0, "R5 empty pop");
    check("R5 rx_rdata kept", int'(rx_rdata), 8'hA5);
    // R6/R7 ignored when bit 0 is 0 (tx holds one byte)
    cfg(8'h06, "R6 R7 ignored no bit0");
    check("R7 tx byte kept", int'(tx_count), 1);
    // R12 entering queue mode clears; R2 mode on
    cfg(8'hC1, "R12 R2 mode on");
    check("R12 tx cleared", int'(tx_count), 0);

    // R10 receive level 12, fill to 16, then overrun (R4)
    for (int i = 0; i < 17; i++) drive(1, 8'(i + 16), 0, 0, 0, 0, "R10 rx fill");
    check("R2 rx depth 16", int'(rx_count), 16);
    drive(1, 8'hEE, 1, 0, 0, 0, "R3 push pop on full");
    for (int i = 0; i < 17; i++) drive(0, 0, 1, 0, 0, 0, "R3 rx drain");

    // R9 transmit level 8
    cfg(8'h21, "R9 tx level 8");
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 1, 8'(i + 100), 0, "R9 tx fill");
    cfg(8'h11, "R9 tx level 4");
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 1, "R9 tx drain");
    cfg(8'h71, "R10 R9 levels 4 and 12");
    for (int i = 0; i < 5; i++) drive(1, 8'(i + 200), 0, 0, 0, 0, "R10 rx level 4");

    // R6 / R7 targeted clears, R8 no stored clear bits
    cfg(8'h03, "R6 rx clear");
    check("R6 tx untouched", int'(tx_count), 4);
    drive(1, 8'h11, 0, 1, 8'h22, 0, "R8 after clear");
    drive(1, 8'h12, 0, 0, 0, 0, "R8 after clear");
    check("R8 rx refills", int'(rx_count), 2);
    cfg(8'h05, "R7 tx clear");
    check("R7 rx untouched", int'(rx_count), 2);
    drive(0, 0, 0, 1, 8'h33, 0, "R8 tx refills");
    // R13 bit 3 only
    cfg(8'h09, "R13 bit3 no effect");
    check("R13 rx kept", int'(rx_count), 2);
    check("R13 tx kept", int'(tx_count), 1);
    drive(0, 0, 1, 0, 0, 1, "R3 pop both");
    drive(0, 0, 1, 0, 0, 0, "R3 pop rx");
    // R12 leave queue mode clears everything
    drive(1, 8'h44, 0, 1, 8'h55, 0, "R12 load");
    cfg(8'h00, "R12 mode off");
    check("R12 rx cleared", int'(rx_count), 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule